// File: doc/BRIEF.md
# Gated Shift-Register Upset Monitor

This block is a long serial chain of flip-flops used to measure how often storage elements and the logic between them are disturbed by radiation. A known bit stream enters the chain one bit per advance. After exactly one chain length of advances, the same bit leaves the far end. A checker inside the block predicts what should come out and flags each bit that differs. A flag means either a flipped flip-flop somewhere along the chain, or a glitch in the gate logic between stages that a flip-flop captured at a clock edge.

Between every pair of neighbouring stages sits a hop path. A build parameter selects what the hop path contains: a bare wire, a run of inverters, a run of two-input AND gates with the spare input held high, or a run of two-input OR gates with the spare input held low. All four pass data through unchanged. They differ only in how much combinational logic is exposed to transients. The chain length, the number of gates per hop and the error counter width are all parameters.

The stream has no back-pressure. `enable` is the advance qualifier: on a clock edge where it is high, the chain shifts and the checker compares one bit. When it is low, nothing moves and nothing is compared. The source must drive `pat_in` with a fixed alternating sequence. Any departure from that sequence behaves exactly like an upset at the chain entry, and the checker reports it when the bit reaches the far end.

Top module: `srum_monitor`

## Requirements
- R1: While `rst_n` is low, `chain_out`, `err_pulse` and `err_count` are all 0. They stay 0 until the first enabled edge after reset is released.
- R2: On an enabled edge, the chain shifts by one stage. `chain_out` then equals the `pat_in` value sampled CHAIN_LEN enabled edges earlier. Until that many enabled edges have occurred since reset, `chain_out` is 0.
- R3: On an edge where `enable` is low, the chain does not shift, no comparison is made, `chain_out` and `err_count` keep their values, and `err_pulse` is 0 in the following cycle.
- R4: Every hop variant passes data through unchanged. This covers the wire, an even count of inverters (an odd count is rejected at elaboration), AND gates with the spare input tied to 1, and OR gates with the spare input tied to 0.
- R5: The checker stays disarmed until CHAIN_LEN enabled edges have occurred since reset. While disarmed, it never raises `err_pulse` and never changes `err_count`, whatever `chain_out` shows.
- R6: Number the enabled edges after reset k = 0, 1, 2, and so on. The reference pattern expects `pat_in` = k mod 2 at edge k. At each armed, enabled edge, `chain_out` is compared with the reference bit from CHAIN_LEN enabled edges earlier. A difference sets `err_pulse` high for the one cycle after that edge. A match sets it low for that cycle.
- R7: Each mismatch adds one to `err_count`. Once the count reaches all ones (2^CNT_W − 1), it saturates there and stays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chain and checker clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance qualifier: shift and compare on this edge |
| pat_in | input | 1 | Serial test bit entering the first stage |
| chain_out | output | 1 | Last stage of the chain |
| err_pulse | output | 1 | High for one cycle after each detected mismatch |
| err_count | output | CNT_W | Saturating mismatch count |

## Verification
The assertions assume that `enable` and `pat_in` are clean, synchronous levels with no unknown values once reset has been released. They also assume that resets are asserted only between whole test runs, so the fill and arming state always starts from zero. The stimulus changes every input on the falling clock edge only. It drives the exact alternating sequence except at chosen edges, where it flips one bit on purpose. Each of these flips stands in for an upset, and the bench predicts the mismatch it should cause CHAIN_LEN enabled edges later. Gaps with `enable` low are mixed into the stream to show that the reference, the fill count and the chain all pause together.

// File: rtl/srum_pkg.sv
package srum_pkg;

  typedef enum logic [1:0] {
    HOP_WIRE = 2'd0,
    HOP_INV  = 2'd1,
    HOP_AND  = 2'd2,
    HOP_OR   = 2'd3
  } hop_kind_e;

endpackage

// File: rtl/srum_hop_path.sv
module srum_hop_path #(
  parameter srum_pkg::hop_kind_e HOP_KIND = srum_pkg::HOP_INV,
  parameter int GATES_PER_HOP = 8
) (
  input  logic d,
  output logic q
);

  if ((HOP_KIND == srum_pkg::HOP_INV) && ((GATES_PER_HOP % 2) != 0)) begin : g_bad_inv_count
    $error("inverter hop needs an even gate count to stay transparent");
  end

  if ((HOP_KIND == srum_pkg::HOP_WIRE) || (GATES_PER_HOP == 0)) begin : g_wire
    assign q = d;
  end else begin : g_gates
    for (genvar i = 0; i < GATES_PER_HOP; i++) begin : g_gate
      logic a;
      logic y;
      if (i == 0) begin : g_first
        assign a = d;
      end else begin : g_next
        assign a = g_gate[i-1].y;
      end
      if (HOP_KIND == srum_pkg::HOP_INV) begin : g_inv
        assign y = ~a;
      end else if (HOP_KIND == srum_pkg::HOP_AND) begin : g_and
        logic tie_hi;
        assign tie_hi = 1'b1;
        assign y = a & tie_hi;
      end else begin : g_or
        logic tie_lo;
        assign tie_lo = 1'b0;
        assign y = a | tie_lo;
      end
    end
    assign q = g_gate[GATES_PER_HOP-1].y;
  end

endmodule

// File: rtl/srum_chain.sv
module srum_chain #(
  parameter int CHAIN_LEN = 350,
  parameter srum_pkg::hop_kind_e HOP_KIND = srum_pkg::HOP_INV,
  parameter int GATES_PER_HOP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pat_in,
  output logic chain_out
);

  logic [CHAIN_LEN-1:0] stg;
  logic [CHAIN_LEN-1:0] stg_next;

  assign stg_next[0] = pat_in;

  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_hop
    srum_hop_path #(
      .HOP_KIND     (HOP_KIND),
      .GATES_PER_HOP(GATES_PER_HOP)
    ) hop_i (
      .d(stg[i-1]),
      .q(stg_next[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (enable) begin
      stg <= stg_next;
    end
  end

  assign chain_out = stg[CHAIN_LEN-1];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(chain_out)); // R3

  if (CHAIN_LEN > 1) begin : g_hop_chk
    AST_HOP_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (stg[1] == $past(stg[0]))); // R4
  end

endmodule

// File: rtl/srum_checker.sv
module srum_checker #(
  parameter int CHAIN_LEN = 350,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             chain_out,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);

  localparam int FILL_W = $clog2(CHAIN_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(CHAIN_LEN);
  localparam logic LAT_ODD = ((CHAIN_LEN % 2) != 0);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              ref_phase;
  logic [FILL_W-1:0] fill;
  logic              armed;
  logic              expect_bit;
  logic              mismatch;

  assign armed      = (fill == FILL_DONE);
  assign expect_bit = ref_phase ^ LAT_ODD;
  assign mismatch   = enable && armed && (chain_out != expect_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_phase <= 1'b0;
      fill      <= '0;
    end else if (enable) begin
      ref_phase <= ~ref_phase;
      if (!armed) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_count <= '0;
    end else begin
      err_pulse <= mismatch;
      if (mismatch && (err_count != CNT_MAX)) err_count <= err_count + 1'b1;
    end
  end

  AST_NO_ERR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !err_pulse); // R5
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !err_pulse); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && ($past(err_count) != CNT_MAX)) |-> (err_count == $past(err_count) + 1'b1)); // R7
  AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_count)); // R7

endmodule

// File: rtl/srum_monitor.sv
module srum_monitor #(
  parameter int CHAIN_LEN = 350,
  parameter srum_pkg::hop_kind_e HOP_KIND = srum_pkg::HOP_INV,
  parameter int GATES_PER_HOP = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pat_in,
  output logic             chain_out,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);

  srum_chain #(
    .CHAIN_LEN    (CHAIN_LEN),
    .HOP_KIND     (HOP_KIND),
    .GATES_PER_HOP(GATES_PER_HOP)
  ) chain_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pat_in   (pat_in),
    .chain_out(chain_out)
  );

  srum_checker #(
    .CHAIN_LEN(CHAIN_LEN),
    .CNT_W    (CNT_W)
  ) checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .chain_out(chain_out),
    .err_pulse(err_pulse),
    .err_count(err_count)
  );

endmodule

// File: tb/srum_monitor_tb_top.sv
`timescale 1ns/1ps
module srum_monitor_tb_top;

  localparam int NDUT = 4;
  localparam int HIST = 8192;
  localparam int LEN [NDUT] = '{350, 6, 7, 5};
  localparam longint CMAX [NDUT] = '{64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd3, 64'hFFFF_FFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic pat_in = 1'b0;

  logic co [NDUT];
  logic ep [NDUT];
  logic [31:0] cnt_i, cnt_and, cnt_wire;
  logic [1:0]  cnt_or;

  int checks = 0;
  int errors = 0;
  int e = 0;
  bit hist [HIST];
  bit     exp_out [NDUT];
  bit     exp_err [NDUT];
  longint exp_cnt [NDUT];
  bit done = 1'b0;

  always #4 clk = ~clk;

  srum_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_in(pat_in),
    .chain_out(co[0]), .err_pulse(ep[0]), .err_count(cnt_i));

  srum_monitor #(.CHAIN_LEN(6), .HOP_KIND(srum_pkg::HOP_AND), .GATES_PER_HOP(8), .CNT_W(32)) dut_and (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_in(pat_in),
    .chain_out(co[1]), .err_pulse(ep[1]), .err_count(cnt_and));

  srum_monitor #(.CHAIN_LEN(7), .HOP_KIND(srum_pkg::HOP_OR), .GATES_PER_HOP(8), .CNT_W(2)) dut_or (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_in(pat_in),
    .chain_out(co[2]), .err_pulse(ep[2]), .err_count(cnt_or));

  srum_monitor #(.CHAIN_LEN(5), .HOP_KIND(srum_pkg::HOP_WIRE), .GATES_PER_HOP(0), .CNT_W(32)) dut_wire (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_in(pat_in),
    .chain_out(co[3]), .err_pulse(ep[3]), .err_count(cnt_wire));

  function automatic longint cnt_of(int d);
    case (d)
      0: return longint'(cnt_i);
      1: return longint'(cnt_and);
      2: return longint'(cnt_or);
      default: return longint'(cnt_wire);
    endcase
  endfunction

  task automatic chk(string req, string what, int d, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s dut%0d: actual %0d expected %0d (edge %0d)", req, what, d, act, exp, e);
    end
  endtask

  task automatic model_reset();
    e = 0;
    for (int d = 0; d < NDUT; d++) begin
      exp_out[d] = 1'b0;
      exp_err[d] = 1'b0;
      exp_cnt[d] = 0;
    end
  endtask

  // one edge: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic do_step(input bit en, input bit flip);
    bit pat;
    pat = bit'(e % 2) ^ flip;
    enable = en;
    pat_in = pat;
    @(posedge clk);
    for (int d = 0; d < NDUT; d++) begin
      exp_err[d] = 1'b0;
      if (en && (e >= LEN[d])) begin
        exp_err[d] = (hist[e - LEN[d]] != bit'((e - LEN[d]) % 2));
        if (exp_err[d] && (exp_cnt[d] != CMAX[d])) exp_cnt[d]++;
      end
    end
    if (en) begin
      hist[e] = pat;
      e++;
    end
    for (int d = 0; d < NDUT; d++)
      exp_out[d] = (e >= LEN[d]) ? hist[e - LEN[d]] : 1'b0;
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      chk(en ? "R2" : "R3", "chain_out", d, longint'(co[d]), longint'(exp_out[d]));
      chk(en ? "R6" : "R3", "err_pulse", d, longint'(ep[d]), longint'(exp_err[d]));
      chk("R7", "err_count", d, cnt_of(d), exp_cnt[d]);
    end
  endtask

  task automatic run_clean(int n);
    for (int i = 0; i < n; i++) do_step(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    enable = 1'b0;
    pat_in = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    for (int d = 0; d < NDUT; d++) begin
      chk("R1", "chain_out in reset", d, longint'(co[d]), 0);
      chk("R1", "err_pulse in reset", d, longint'(ep[d]), 0);
      chk("R1", "err_count in reset", d, cnt_of(d), 0);
    end
    rst_n = 1'b1;
    do_step(1'b0, 1'b0);
  endtask

  // R5: the fill phase shows zeros that do not match the parity, yet no error fires
  task automatic t_fill_unarmed();
    run_clean(360);
    for (int d = 0; d < NDUT; d++) chk("R5", "no count after fill", d, cnt_of(d), 0);
  endtask

  // R3: idle gaps freeze chain, reference and counter
  task automatic t_idle_gaps();
    for (int i = 0; i < 60; i++) do_step((i % 3) != 1, 1'b0);
    repeat (12) do_step(1'b0, 1'b0);
    run_clean(10);
  endtask

  // R6/R4: isolated flipped bits emerge after each chain length through every hop variant
  task automatic t_single_upsets();
    do_step(1'b1, 1'b1);
    run_clean(9);
    do_step(1'b1, 1'b1);
    do_step(1'b0, 1'b0);
    run_clean(360);
  endtask

  // R6: consecutive flips give consecutive pulses
  task automatic t_back_to_back();
    do_step(1'b1, 1'b1);
    do_step(1'b1, 1'b1);
    do_step(1'b1, 1'b1);
    run_clean(360);
  endtask

  // R7: the 2-bit counter of dut_or saturates at 3
  task automatic t_saturate();
    for (int i = 0; i < 6; i++) begin
      do_step(1'b1, 1'b1);
      run_clean(3);
    end
    run_clean(20);
    chk("R7", "saturated count", 2, longint'(cnt_or), 3);
  endtask

  // R1/R5: reset in the middle of a run clears and re-arms from zero
  task automatic t_midrun_reset();
    do_step(1'b1, 1'b1);
    run_clean(2);
    t_reset();
    run_clean(360);
    for (int d = 0; d < NDUT; d++) chk("R5", "clean after re-fill", d, cnt_of(d), 0);
  endtask

  initial begin
    model_reset();
    t_reset();
    t_fill_unarmed();
    t_idle_gaps();
    t_single_upsets();
    t_back_to_back();
    t_saturate();
    t_midrun_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule